// File: doc/BRIEF.md
# Byte-Wide External Memory Bus Bridge

The bridge links an internal load/store request port carrying up to 32 bits of data to an external asynchronous memory bus. The external bus is one byte wide. It has a 16-bit address, separate byte output and input paths with an output enable, active-low read and write strobes, and seven active-low chip selects. Each request is one byte, a half-word or a word. Wider requests become a run of byte cycles at consecutive addresses, least significant byte first. Read bytes are gathered into a little-endian result, which is returned with a one-clock done pulse.

The chip select for a request is chosen when the request is accepted. Select 0 is the default data-memory select. Selects 1 to 6 each compare a base value against the top address bits. Each select has its own wait-clock count, and that count stretches the strobe phase of every byte cycle of the access. A mode input hands selects 1 to 6 over to general-purpose use. They then stay inactive, and every access goes to select 0.

Top module: `xb_bridge`

## Requirements
- R1: `ack` is high exactly when `req` is high while the bridge is idle, and the bridge is idle in the cycle that carries `done`. A request made while an access is in progress gets no `ack` and causes no bus activity of its own.
- R2: `req_size` sets the number of byte cycles: 0 gives one, 1 gives two, and 2 or 3 give four.
- R3: Each byte cycle is one setup clock with both strobes high, followed by a strobe phase of 1+W clocks. `bus_rd_n` is low during the strobe phase for a read, and `bus_wr_n` is low for a write. W is the wait entry of the chosen select, where entry values 0, 1 and 2 give W = 0, 1 and 2 and value 3 gives W = 2. The two strobes are never low together.
- R4: Byte cycle k of an access uses address `req_addr + k` modulo 2^16. For a write, byte k drives `req_wdata[8k+7:8k]` with `bus_doe` high over the whole byte cycle. `bus_doe` is low at all other times.
- R5: For a read, byte k is sampled from `bus_din` on the last clock of its strobe phase and placed in `rdata[8k+7:8k]`. Bytes not read are zero. `rdata` is valid while `done` is high.
- R6: `done` is high for exactly one clock, the clock after the last strobe clock of the access.
- R7: Select j (1..6) is chosen when `req_addr[15:12]` equals its base field `cfg_base[4(j-1)+3:4(j-1)]`, and the lowest matching j wins. With no match, select 0 is chosen. Exactly that one select is held low from the first setup clock to the last strobe clock of the access. The select is not re-decoded while the address advances.
- R8: While `cfg_gpio` is 1, selects 1 to 6 are never asserted, and every access uses select 0 and its wait entry `cfg_wait[1:0]`.
- R9: After reset, and whenever idle, all selects and both strobes are high, `bus_doe` and `done` are low, and `bus_addr` holds the address of the last byte cycle (0 after reset).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request valid |
| req_we | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 half-word, 2/3 word |
| req_addr | input | 16 | Byte address of the first byte |
| req_wdata | input | 32 | Write data, little-endian |
| ack | output | 1 | Request accepted this clock |
| done | output | 1 | Access finished (one clock) |
| rdata | output | 32 | Assembled read data |
| cfg_base | input | 24 | Base nibbles of selects 1..6, 4 bits each |
| cfg_wait | input | 14 | Wait entries of selects 0..6, 2 bits each |
| cfg_gpio | input | 1 | 1 = selects 1..6 released for general-purpose use |
| bus_addr | output | 16 | External byte address |
| bus_dout | output | 8 | External write data |
| bus_doe | output | 1 | External data output enable |
| bus_din | input | 8 | External read data |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |
| bus_cs_n | output | 7 | Chip selects, active low |

## Verification
The bench uses the default parameters: a 16-bit address, seven selects and 4-bit base fields compared against address bits 15:12. With these values the bench can give two selects the same base to test the priority rule, and can set a wait entry to 3 to test the clamp. It can also wrap a word access past address 0xFFFF, and it can run an access across a nibble boundary to show that the select is not re-decoded. The memory model returns a byte that depends on the address. This makes any read captured at the wrong clock or placed in the wrong byte lane show up in `rdata`.

// File: rtl/xb_pkg.sv
package xb_pkg;

    localparam int XB_WAIT_W = 2;
    localparam int XB_BYTE_W = 8;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SETUP  = 2'd1,
        ST_STROBE = 2'd2
    } xb_state_e;

    typedef struct packed {
        logic                 we;
        logic [2:0]           nbytes;
        logic [XB_WAIT_W-1:0] waits;
    } xb_job_t;

    // Byte cycles needed for a size code: 0 -> 1, 1 -> 2, otherwise 4.
    function automatic logic [2:0] xb_size_bytes(input logic [1:0] sz);
        case (sz)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            default: return 3'd4;
        endcase
    endfunction

    // Wait entries above two clocks are limited to two.
    function automatic logic [XB_WAIT_W-1:0] xb_clamp_wait(input logic [XB_WAIT_W-1:0] w);
        return (w > 2'd2) ? 2'd2 : w;
    endfunction

endpackage

// File: rtl/xb_cs_decode.sv
module xb_cs_decode
    import xb_pkg::*;
#(
    parameter int NUM_SEL = 7,
    parameter int BASE_W  = 4,
    localparam int IDX_W  = $clog2(NUM_SEL)
) (
    input  logic [BASE_W-1:0]              addr_hi,
    input  logic [(NUM_SEL-1)*BASE_W-1:0]  cfg_base,
    input  logic [NUM_SEL*XB_WAIT_W-1:0]   cfg_wait,
    input  logic                           cfg_gpio,
    output logic [IDX_W-1:0]               sel_idx,
    output logic [XB_WAIT_W-1:0]           sel_wait
);

    always_comb begin
        sel_idx = '0;
        // Descending scan so the lowest matching select is the last to write.
        for (int j = NUM_SEL - 1; j >= 1; j--) begin
            if (!cfg_gpio && addr_hi == cfg_base[(j-1)*BASE_W +: BASE_W])
                sel_idx = IDX_W'(j);
        end
        sel_wait = xb_clamp_wait(cfg_wait[sel_idx*XB_WAIT_W +: XB_WAIT_W]);
    end

endmodule

// File: rtl/xb_rd_assembler.sv
module xb_rd_assembler
    import xb_pkg::*;
#(
    parameter int WORD_BYTES = 4,
    localparam int LANE_W    = $clog2(WORD_BYTES)
) (
    input  logic                            clk,
    input  logic                            rst,
    input  logic                            clear,
    input  logic                            cap_en,
    input  logic [LANE_W-1:0]               cap_lane,
    input  logic [XB_BYTE_W-1:0]            bus_din,
    output logic [WORD_BYTES*XB_BYTE_W-1:0] rdata
);

    always_ff @(posedge clk) begin
        if (rst || clear)
            rdata <= '0;
        else if (cap_en)
            rdata[cap_lane*XB_BYTE_W +: XB_BYTE_W] <= bus_din;
    end

endmodule

// File: rtl/xb_sequencer.sv
module xb_sequencer
    import xb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_SEL    = 7,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NUM_SEL),
    localparam int LANE_W    = $clog2(WORD_BYTES),
    localparam int WORD_W    = WORD_BYTES * XB_BYTE_W
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  req,
    input  logic                  req_we,
    input  logic [1:0]            req_size,
    input  logic [ADDR_W-1:0]     req_addr,
    input  logic [WORD_W-1:0]     req_wdata,
    input  logic [IDX_W-1:0]      sel_idx,
    input  logic [XB_WAIT_W-1:0]  sel_wait,
    output logic                  ack,
    output logic                  done,
    output logic                  cap_en,
    output logic [LANE_W-1:0]     cap_lane,
    output logic [ADDR_W-1:0]     bus_addr,
    output logic [XB_BYTE_W-1:0]  bus_dout,
    output logic                  bus_doe,
    output logic                  bus_rd_n,
    output logic                  bus_wr_n,
    output logic [NUM_SEL-1:0]    bus_cs_n
);

    xb_state_e               state;
    xb_job_t                 job;
    logic [WORD_W-1:0]       wdata_q;
    logic [IDX_W-1:0]        cs_q;
    logic [LANE_W-1:0]       lane_q;
    logic [XB_WAIT_W-1:0]    wcnt_q;
    logic                    strobe_last;
    logic                    byte_last;

    assign ack         = req && (state == ST_IDLE);
    assign strobe_last = (state == ST_STROBE) && (wcnt_q == job.waits);
    assign byte_last   = ({1'b0, lane_q} == job.nbytes - 3'd1);
    assign cap_en      = strobe_last && !job.we;
    assign cap_lane    = lane_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state    <= ST_IDLE;
            job      <= '0;
            wdata_q  <= '0;
            cs_q     <= '0;
            lane_q   <= '0;
            wcnt_q   <= '0;
            bus_addr <= '0;
            done     <= 1'b0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_IDLE: if (req) begin
                    job      <= '{we: req_we, nbytes: xb_size_bytes(req_size), waits: sel_wait};
                    wdata_q  <= req_wdata;
                    cs_q     <= sel_idx;
                    lane_q   <= '0;
                    bus_addr <= req_addr;
                    state    <= ST_SETUP;
                end
                ST_SETUP: begin
                    wcnt_q <= '0;
                    state  <= ST_STROBE;
                end
                ST_STROBE: begin
                    if (!strobe_last) begin
                        wcnt_q <= wcnt_q + 1'b1;
                    end else if (byte_last) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        lane_q   <= lane_q + 1'b1;
                        bus_addr <= bus_addr + 1'b1;
                        state    <= ST_SETUP;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    always_comb begin
        bus_doe  = (state != ST_IDLE) && job.we;
        bus_dout = wdata_q[lane_q*XB_BYTE_W +: XB_BYTE_W];
        bus_rd_n = !((state == ST_STROBE) && !job.we);
        bus_wr_n = !((state == ST_STROBE) && job.we);
        for (int j = 0; j < NUM_SEL; j++)
            bus_cs_n[j] = !((state != ST_IDLE) && (cs_q == IDX_W'(j)));
    end

endmodule

// File: rtl/xb_bridge.sv
module xb_bridge
    import xb_pkg::*;
#(
    parameter int ADDR_W     = 16,
    parameter int NUM_SEL    = 7,
    parameter int BASE_W     = 4,
    parameter int WORD_BYTES = 4,
    localparam int IDX_W     = $clog2(NUM_SEL),
    localparam int LANE_W    = $clog2(WORD_BYTES),
    localparam int WORD_W    = WORD_BYTES * XB_BYTE_W
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           req,
    input  logic                           req_we,
    input  logic [1:0]                     req_size,
    input  logic [ADDR_W-1:0]              req_addr,
    input  logic [WORD_W-1:0]              req_wdata,
    output logic                           ack,
    output logic                           done,
    output logic [WORD_W-1:0]              rdata,
    input  logic [(NUM_SEL-1)*BASE_W-1:0]  cfg_base,
    input  logic [NUM_SEL*XB_WAIT_W-1:0]   cfg_wait,
    input  logic                           cfg_gpio,
    output logic [ADDR_W-1:0]              bus_addr,
    output logic [XB_BYTE_W-1:0]           bus_dout,
    output logic                           bus_doe,
    input  logic [XB_BYTE_W-1:0]           bus_din,
    output logic                           bus_rd_n,
    output logic                           bus_wr_n,
    output logic [NUM_SEL-1:0]             bus_cs_n
);

    logic [IDX_W-1:0]     sel_idx;
    logic [XB_WAIT_W-1:0] sel_wait;
    logic                 cap_en;
    logic [LANE_W-1:0]    cap_lane;

    xb_cs_decode #(.NUM_SEL(NUM_SEL), .BASE_W(BASE_W)) u_dec (
        .addr_hi  (req_addr[ADDR_W-1 -: BASE_W]),
        .cfg_base (cfg_base),
        .cfg_wait (cfg_wait),
        .cfg_gpio (cfg_gpio),
        .sel_idx  (sel_idx),
        .sel_wait (sel_wait)
    );

    xb_sequencer #(.ADDR_W(ADDR_W), .NUM_SEL(NUM_SEL), .WORD_BYTES(WORD_BYTES)) u_seq (
        .clk       (clk),
        .rst       (rst),
        .req       (req),
        .req_we    (req_we),
        .req_size  (req_size),
        .req_addr  (req_addr),
        .req_wdata (req_wdata),
        .sel_idx   (sel_idx),
        .sel_wait  (sel_wait),
        .ack       (ack),
        .done      (done),
        .cap_en    (cap_en),
        .cap_lane  (cap_lane),
        .bus_addr  (bus_addr),
        .bus_dout  (bus_dout),
        .bus_doe   (bus_doe),
        .bus_rd_n  (bus_rd_n),
        .bus_wr_n  (bus_wr_n),
        .bus_cs_n  (bus_cs_n)
    );

    xb_rd_assembler #(.WORD_BYTES(WORD_BYTES)) u_asm (
        .clk      (clk),
        .rst      (rst),
        .clear    (ack),
        .cap_en   (cap_en),
        .cap_lane (cap_lane),
        .bus_din  (bus_din),
        .rdata    (rdata)
    );

endmodule

// File: rtl/xb_checker.sv
module xb_checker #(
    parameter int NUM_SEL = 7
) (
    input logic               clk,
    input logic               rst,
    input logic               ack,
    input logic               done,
    input logic               cfg_gpio,
    input logic               bus_doe,
    input logic               bus_rd_n,
    input logic               bus_wr_n,
    input logic [NUM_SEL-1:0] bus_cs_n
);

    logic [2:0] strobe_run;

    always_ff @(posedge clk) begin
        if (rst)
            strobe_run <= '0;
        else if (!bus_rd_n || !bus_wr_n)
            strobe_run <= (strobe_run == 3'd7) ? 3'd7 : strobe_run + 3'd1;
        else
            strobe_run <= '0;
    end

    p_ack_when_idle_r1: assert property (@(posedge clk) disable iff (rst)
        ack |-> (&bus_cs_n && bus_rd_n && bus_wr_n));

    p_strobe_exclusive_r3: assert property (@(posedge clk) disable iff (rst)
        !(!bus_rd_n && !bus_wr_n));

    p_setup_before_strobe_r3: assert property (@(posedge clk) disable iff (rst)
        ($fell(bus_rd_n) || $fell(bus_wr_n)) |-> $past(!(&bus_cs_n)));

    p_wait_limit_r3: assert property (@(posedge clk) disable iff (rst)
        (!bus_rd_n || !bus_wr_n) |-> (strobe_run < 3'd3));

    p_write_drives_r4: assert property (@(posedge clk) disable iff (rst)
        !bus_wr_n |-> bus_doe);

    p_no_contention_r4: assert property (@(posedge clk) disable iff (rst)
        bus_doe |-> bus_rd_n);

    p_done_single_r6: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    p_done_follows_strobe_r6: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(!bus_rd_n || !bus_wr_n));

    p_one_select_r7: assert property (@(posedge clk) disable iff (rst)
        $onehot0(~bus_cs_n));

    p_gpio_release_r8: assert property (@(posedge clk) disable iff (rst)
        (ack && cfg_gpio) |=> (&bus_cs_n[NUM_SEL-1:1]));

endmodule

bind xb_bridge xb_checker #(.NUM_SEL(NUM_SEL)) u_chk (
    .clk      (clk),
    .rst      (rst),
    .ack      (ack),
    .done     (done),
    .cfg_gpio (cfg_gpio),
    .bus_doe  (bus_doe),
    .bus_rd_n (bus_rd_n),
    .bus_wr_n (bus_wr_n),
    .bus_cs_n (bus_cs_n)
);

// File: tb/tb_xb_bridge.sv
module tb_xb_bridge;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req = 1'b0, req_we = 1'b0;
    logic [1:0]  req_size = '0;
    logic [15:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        ack, done;
    logic [31:0] rdata;
    logic [23:0] cfg_base;
    logic [13:0] cfg_wait;
    logic        cfg_gpio = 1'b0;
    logic [15:0] bus_addr;
    logic [7:0]  bus_dout, bus_din;
    logic        bus_doe, bus_rd_n, bus_wr_n;
    logic [6:0]  bus_cs_n;

    logic [3:0] base_tab [1:6];
    logic [1:0] wait_tab [0:6];

    always #2 clk = ~clk;

    always_comb begin
        for (int j = 1; j <= 6; j++) cfg_base[(j-1)*4 +: 4] = base_tab[j];
        for (int j = 0; j <= 6; j++) cfg_wait[j*2 +: 2] = wait_tab[j];
    end

    // Memory model: byte returned depends on the address.
    assign bus_din = bus_addr[7:0] ^ 8'h5A;

    xb_bridge dut (.*);

    typedef struct {
        logic [6:0]  cs_n;
        logic        rd_n, wr_n, doe, done, is_rd;
        logic [15:0] addr;
        logic [7:0]  dout;
        logic [31:0] rdata;
    } exp_t;

    exp_t        q[$];
    logic [15:0] hold_addr = '0;
    int          n_tests = 0, n_fail = 0;

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %h expected %h", tag, $time, act, exp);
        end
    endtask

    task automatic tick();
        exp_t e;
        @(negedge clk);
        if (q.size() != 0) e = q.pop_front();
        else e = '{cs_n: '1, rd_n: 1, wr_n: 1, doe: 0, done: 0, is_rd: 0,
                   addr: hold_addr, dout: '0, rdata: '0};
        chk("R7 cs", 32'(bus_cs_n), 32'(e.cs_n));
        chk("R3 rd_n", 32'(bus_rd_n), 32'(e.rd_n));
        chk("R3 wr_n", 32'(bus_wr_n), 32'(e.wr_n));
        chk("R4 doe", 32'(bus_doe), 32'(e.doe));
        chk("R4 addr", 32'(bus_addr), 32'(e.addr));
        if (e.doe) chk("R4 dout", 32'(bus_dout), 32'(e.dout));
        chk("R6 done", 32'(done), 32'(e.done));
        if (e.done && e.is_rd) chk("R5 rdata", rdata, e.rdata);
    endtask

    task automatic model_accept(input logic we, input logic [1:0] sz,
                                input logic [15:0] a, input logic [31:0] wd);
        int   n = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
        int   c = 0;
        int   w;
        logic [31:0] rd = '0;
        exp_t e;
        if (!cfg_gpio)
            for (int j = 1; j <= 6; j++)
                if (a[15:12] == base_tab[j]) begin c = j; break; end
        w = (wait_tab[c] > 2) ? 2 : int'(wait_tab[c]);
        for (int k = 0; k < n; k++) begin
            logic [15:0] ad = a + 16'(k);
            e = '{cs_n: ~(7'd1 << c), rd_n: 1, wr_n: 1, doe: we, done: 0, is_rd: 0,
                  addr: ad, dout: wd[8*k +: 8], rdata: '0};
            q.push_back(e);
            for (int s = 0; s <= w; s++) begin
                e.rd_n = we; e.wr_n = !we;
                q.push_back(e);
            end
            if (!we) rd[8*k +: 8] = ad[7:0] ^ 8'h5A;
        end
        hold_addr = a + 16'(n - 1);
        e = '{cs_n: '1, rd_n: 1, wr_n: 1, doe: 0, done: 1, is_rd: !we,
              addr: hold_addr, dout: '0, rdata: rd};
        q.push_back(e);
    endtask

    task automatic send(input logic we, input logic [1:0] sz,
                        input logic [15:0] a, input logic [31:0] wd);
        logic exp_ack = (q.size() == 0);
        req = 1'b1; req_we = we; req_size = sz; req_addr = a; req_wdata = wd;
        #1;
        chk("R1 ack", 32'(ack), 32'(exp_ack));
        if (exp_ack) model_accept(we, sz, a, wd);
        tick();
        req = 1'b0;
    endtask

    task automatic wait_idle();
        while (q.size() != 0) tick();
    endtask

    initial begin
        base_tab[1] = 4'h1; base_tab[2] = 4'h2; base_tab[3] = 4'h2;
        base_tab[4] = 4'h8; base_tab[5] = 4'h9; base_tab[6] = 4'hA;
        wait_tab[0] = 2'd0; wait_tab[1] = 2'd1; wait_tab[2] = 2'd2; wait_tab[3] = 2'd0;
        wait_tab[4] = 2'd3; wait_tab[5] = 2'd1; wait_tab[6] = 2'd0;
        repeat (3) @(posedge clk);
        @(negedge clk) rst = 1'b0;
        // R9: reset / idle state
        repeat (3) tick();
        // R2 R4: single byte write, select 0, no waits
        send(1'b1, 2'd0, 16'h0010, 32'h0000_00C3);
        wait_idle();
        // R5 R3: half-word read, select 1, one wait
        send(1'b0, 2'd1, 16'h1234, '0);
        wait_idle();
        // R7: duplicate bases, lowest select wins; two waits; crosses nibble
        send(1'b1, 2'd2, 16'h2FFE, 32'hA1B2_C3D4);
        wait_idle();
        // R3: wait entry 3 clamps to two
        send(1'b0, 2'd2, 16'h8000, '0);
        wait_idle();
        // R2 R4: size code 3 acts as word; address wraps past 0xFFFF
        send(1'b0, 2'd3, 16'hFFFE, '0);
        tick();
        // R1: request while busy is ignored
        send(1'b1, 2'd2, 16'h9000, 32'hDEAD_BEEF);
        wait_idle();
        // R6 R1: back-to-back requests issued in the done cycle
        send(1'b1, 2'd1, 16'h9ABC, 32'h0000_5566);
        wait_idle();
        send(1'b0, 2'd0, 16'hA0F0, '0);
        wait_idle();
        repeat (2) tick();
        // R8: select release mode routes everything to select 0
        cfg_gpio = 1'b1;
        send(1'b0, 2'd2, 16'h1000, '0);
        wait_idle();
        send(1'b1, 2'd1, 16'h8888, 32'h0000_7788);
        wait_idle();
        cfg_gpio = 1'b0;
        repeat (3) tick();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog R1: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule